// File: doc/BRIEF.md
# MDIO Serial Management Slave

This block is the management-side slave of a two-wire serial management link. It watches a clock line and a data line from a management master. On every rising edge of the management clock it takes one step through a seven-state frame engine. It decodes read and write frames in the usual 22-style layout, and it turns each valid frame into one access on a simple 16-bit register port. That port carries an address, write data, a write strobe, a read strobe and read data.

The block serves a single device, so the device-address field of a frame is shifted in and then discarded. In a read frame the slave takes the data line through a data output and an output enable. It drives a turnaround zero and then the sixteen register bits. A write frame skips two turnaround bits, collects sixteen data bits and issues a single write strobe. Any opcode other than read or write sends the engine back to idle.

Both line inputs pass through synchronizer flops in the core clock domain before use. The management clock must therefore run several times slower than the core clock.

Top module: `mdio_slave`

## Requirements
- R1: After synchronous reset the engine is idle, `mdio_oe` and `mdio_o` are 0, and neither `reg_we` nor `reg_re` is high.
- R2: While idle, sampled ones (preamble) of any length cause no register access and no drive; the first sampled 0 is taken as the first start bit.
- R3: After the start pair 0 then 1, exactly 12 bits are shifted in MSB first: a 2-bit opcode, a 5-bit device address and a 5-bit register address. The device address has no effect on the result.
- R4: With opcode 2'b10 (read), `reg_re` pulses for one core cycle soon after the 12th header bit, with `reg_addr` equal to the register-address field. `reg_rdata` is captured in that cycle.
- R5: In a read, the slave drives 0 for one management-clock period (turnaround). It then drives the 16 captured bits MSB first, and each bit is replaced after the next rising management-clock edge. After the 16th edge the slave releases the line.
- R6: With opcode 2'b01 (write), the next two bits are ignored whatever their value. Sixteen data bits follow MSB first. After the 16th, exactly one `reg_we` pulse carries the frame's register address on `reg_addr` and the data on `reg_wdata`.
- R7: Opcodes 2'b00 and 2'b11 return the engine to idle with no register access and no drive. The next frame is decoded normally.
- R8: `mdio_oe` is high only during the read turnaround and read data periods. Whenever `mdio_oe` is low, `mdio_o` is 0.
- R9: `reg_we` and `reg_re` are single-cycle pulses, never high together, and exactly one pulse is issued per valid frame.
- R10: A synchronous reset in the middle of a frame drops any drive at once. The next complete frame is decoded normally.
- R11: Each rising management-clock edge advances the engine by exactly one bit. Holding the clock high, and changing the data line while it is high, has no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| mdc | input | 1 | Management clock from the master (asynchronous) |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven in read frames |
| mdio_oe | output | 1 | Output enable for the data line |
| reg_addr | output | 5 | Register address of the current access |
| reg_wdata | output | 16 | Write data, valid with `reg_we` |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 16 | Register read data, sampled while `reg_re` is high |

## Verification
The hardest situation to reach from the ports is one where a single management-clock edge is stretched over many core cycles while the data line toggles under it. From outside, only a corrupted write value would reveal it. The bench stretches one chosen data bit of a write frame and flips the data line halfway through the high phase. It then reads the register back through a normal read frame. Resets are also placed inside a write header and inside a read turnaround. These show that a half-finished frame leaves no drive and no stray strobe behind.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    localparam int OP_W = 2;
    localparam logic [OP_W-1:0] OPC_READ  = 2'b10;
    localparam logic [OP_W-1:0] OPC_WRITE = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_HDR     = 3'd2,
        ST_TA_RD   = 3'd3,
        ST_TA_WR   = 3'd4,
        ST_RD_DATA = 3'd5,
        ST_WR_DATA = 3'd6
    } mdio_state_e;

endpackage

// File: rtl/mdio_line_sync.sv
module mdio_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_in,
    input  logic mdio_in,
    output logic mdc_rise,
    output logic mdio_bit
);
    logic [STAGES-1:0] mdc_pipe_d, mdc_pipe_q;
    logic [STAGES-1:0] dat_pipe_d, dat_pipe_q;
    logic              mdc_last_d, mdc_last_q;

    assign mdc_pipe_d[0] = mdc_in;
    assign dat_pipe_d[0] = mdio_in;

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_chain
            assign mdc_pipe_d[g] = mdc_pipe_q[g-1];
            assign dat_pipe_d[g] = dat_pipe_q[g-1];
        end
    endgenerate

    always_comb begin
        mdc_last_d = mdc_pipe_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_pipe_q <= '0;
            dat_pipe_q <= '1;
            mdc_last_q <= 1'b0;
        end else begin
            mdc_pipe_q <= mdc_pipe_d;
            dat_pipe_q <= dat_pipe_d;
            mdc_last_q <= mdc_last_d;
        end
    end

    assign mdc_rise = mdc_pipe_q[STAGES-1] & ~mdc_last_q;
    assign mdio_bit = dat_pipe_q[STAGES-1];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mdc_rise |=> !mdc_rise); // R11

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_slave_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 5,
    parameter int PHY_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [DATA_W-1:0] rd_data,
    output logic              drv_en,
    output logic              drv_val,
    output logic [REG_AW-1:0] acc_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              rd_stb
);
    localparam int HDR_BITS = OP_W + PHY_AW + REG_AW;
    localparam int MAXCNT   = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;
    localparam int CNT_W    = $clog2(MAXCNT + 1);
    localparam int TA_WR_N  = 2;

    typedef struct packed {
        mdio_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] acc;
        logic [REG_AW-1:0] addr;
        logic              we;
        logic              re;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_IDLE, cnt: '0, acc: '0, addr: '0,
                                 we: 1'b0, re: 1'b0};

    eng_t q, d;
    logic [DATA_W-1:0]   acc_in;
    logic [HDR_BITS-1:0] hdr;
    logic [OP_W-1:0]     opc;
    logic                last_bit;

    assign acc_in   = {q.acc[DATA_W-2:0], bit_val};
    assign hdr      = acc_in[HDR_BITS-1:0];
    assign opc      = hdr[HDR_BITS-1 -: OP_W];
    assign last_bit = (q.cnt == CNT_W'(1));

    always_comb begin
        d    = q;
        d.we = 1'b0;
        d.re = 1'b0;
        // read data arrives in the cycle the read strobe is up
        if (q.re) begin
            d.acc = rd_data;
        end
        if (bit_stb) begin
            case (q.st)
                ST_IDLE: begin
                    if (!bit_val) d.st = ST_START;
                end
                ST_START: begin
                    if (bit_val) begin
                        d.st  = ST_HDR;
                        d.cnt = CNT_W'(HDR_BITS);
                        d.acc = '0;
                    end
                end
                ST_HDR: begin
                    d.acc = acc_in;
                    d.cnt = q.cnt - 1'b1;
                    if (last_bit) begin
                        if (opc == OPC_READ) begin
                            d.addr = hdr[REG_AW-1:0];
                            d.re   = 1'b1;
                            d.st   = ST_TA_RD;
                        end else if (opc == OPC_WRITE) begin
                            d.addr = hdr[REG_AW-1:0];
                            d.cnt  = CNT_W'(TA_WR_N);
                            d.st   = ST_TA_WR;
                        end else begin
                            d.st   = ST_IDLE;
                        end
                    end
                end
                ST_TA_RD: begin
                    d.st  = ST_RD_DATA;
                    d.cnt = CNT_W'(DATA_W);
                end
                ST_TA_WR: begin
                    d.cnt = q.cnt - 1'b1;
                    if (last_bit) begin
                        d.st  = ST_WR_DATA;
                        d.cnt = CNT_W'(DATA_W);
                    end
                end
                ST_RD_DATA: begin
                    d.acc = {q.acc[DATA_W-2:0], 1'b0};
                    d.cnt = q.cnt - 1'b1;
                    if (last_bit) d.st = ST_IDLE;
                end
                ST_WR_DATA: begin
                    d.acc = acc_in;
                    d.cnt = q.cnt - 1'b1;
                    if (last_bit) begin
                        d.we = 1'b1;
                        d.st = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= ENG_RST;
        else     q <= d;
    end

    assign drv_en   = (q.st == ST_TA_RD) || (q.st == ST_RD_DATA);
    assign drv_val  = (q.st == ST_RD_DATA) ? q.acc[DATA_W-1] : 1'b0;
    assign acc_addr = q.addr;
    assign wr_data  = q.acc;
    assign wr_stb   = q.we;
    assign rd_stb   = q.re;

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(q.we && q.re)); // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        q.we |=> !q.we); // R9
    AST_RE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        q.re |=> !q.re); // R9
    AST_RE_IN_TA: assert property (@(posedge clk) disable iff (rst)
        q.re |-> (q.st == ST_TA_RD)); // R4
    AST_WE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        q.we |-> (q.st == ST_IDLE)); // R6
    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(q.st)); // R11
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        q.cnt <= CNT_W'(MAXCNT)); // R3

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
    import mdio_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 16,
    parameter int REG_AW      = 5,
    parameter int PHY_AW      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic edge_stb;
    logic edge_bit;

    mdio_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .mdc_in   (mdc),
        .mdio_in  (mdio_i),
        .mdc_rise (edge_stb),
        .mdio_bit (edge_bit)
    );

    mdio_frame_engine #(.DATA_W(DATA_W), .REG_AW(REG_AW), .PHY_AW(PHY_AW)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (edge_stb),
        .bit_val  (edge_bit),
        .rd_data  (reg_rdata),
        .drv_en   (mdio_oe),
        .drv_val  (mdio_o),
        .acc_addr (reg_addr),
        .wr_data  (reg_wdata),
        .wr_stb   (reg_we),
        .rd_stb   (reg_re)
    );

    AST_OE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> !mdio_o); // R8
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !mdio_oe); // R8

endmodule

// File: tb/mdio_slave_test.sv
module mdio_slave_test;
    localparam int HP = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        mdc;
    logic        mdio_i;
    logic        mdio_o;
    logic        mdio_oe;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic        reg_re;
    logic [15:0] reg_rdata;

    always #5 clk = ~clk;

    mdio_slave uut (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    // register file seen by the slave, and the bench's own expectation of it
    logic [15:0] rf [32];
    logic [15:0] em [32];
    assign reg_rdata = rf[reg_addr];
    always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        bit          is_wr;
        logic [4:0]  a;
        logic [15:0] d;
        string       req;
    } ev_t;
    ev_t exp_q[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected access per strobe
    always @(negedge clk) begin
        if (!rst && (reg_we || reg_re)) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected strobe", {reg_we, reg_re, reg_addr}, 0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                chk({e.req, " kind"}, {reg_we, reg_re}, e.is_wr ? 2'b10 : 2'b01);
                chk({e.req, " addr"}, reg_addr, e.a);
                if (e.is_wr) chk({e.req, " data"}, reg_wdata, e.d);
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic step(bit b, int hold = HP, bit flip = 1'b0);
        mdio_i = b;
        repeat (HP) @(negedge clk);
        mdc = 1'b1;
        repeat (hold / 2) @(negedge clk);
        if (flip) mdio_i = ~b;
        repeat (hold - hold / 2) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic hdr(logic [1:0] op, logic [4:0] phy, logic [4:0] ra, int npre);
        logic [11:0] h;
        h = {op, phy, ra};
        for (int i = 0; i < npre; i++) step(1'b1);
        step(1'b0);
        step(1'b1);
        for (int i = 11; i >= 0; i--) step(h[i]);
    endtask

    task automatic rd_frame(logic [4:0] phy, logic [4:0] ra, int npre = 4);
        logic [15:0] w;
        exp_q.push_back('{0, ra, 16'h0, "R4"});
        hdr(2'b10, phy, ra, npre);
        mdio_i = 1'b1;
        repeat (HP) @(negedge clk);
        chk("R5 turnaround", {mdio_oe, mdio_o}, 2'b10);
        mdc = 1'b1; repeat (HP) @(negedge clk); mdc = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            repeat (HP) @(negedge clk);
            w[i] = mdio_o;
            if (!mdio_oe) w[i] = 1'bx;
            mdc = 1'b1; repeat (HP) @(negedge clk); mdc = 1'b0;
        end
        chk("R5 read word", w, em[ra]);
        repeat (HP) @(negedge clk);
        chk("R8 released after read", {mdio_oe, mdio_o}, 2'b00);
    endtask

    task automatic wr_frame(logic [4:0] phy, logic [4:0] ra, logic [15:0] dv,
                            logic [1:0] ta, int long_idx = -1);
        bit drove;
        drove = 1'b0;
        exp_q.push_back('{1, ra, dv, "R6"});
        em[ra] = dv;
        hdr(2'b01, phy, ra, 4);
        step(ta[1]);
        step(ta[0]);
        for (int i = 15; i >= 0; i--) begin
            if (mdio_oe) drove = 1'b1;
            if (i == long_idx) step(dv[i], 60, 1'b1);
            else               step(dv[i]);
        end
        repeat (HP) @(negedge clk);
        chk("R8 no drive in write", drove, 1'b0);
        mdio_i = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            rf[i] = 16'hA5C3 ^ 16'(i * 16'h0137);
            em[i] = rf[i];
        end
        rst = 1'b1; mdc = 1'b0; mdio_i = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset outputs", {mdio_oe, mdio_o, reg_we, reg_re}, 4'b0000);

        // R2: long preamble alone, no access and no drive
        for (int i = 0; i < 40; i++) step(1'b1);
        repeat (HP) @(negedge clk);
        chk("R2 preamble idle", {mdio_oe, 32'(exp_q.size())}, 0);

        // R6 / R4 / R5 basic write then read back
        wr_frame(5'h00, 5'd4, 16'h1234, 2'b10);
        rd_frame(5'h00, 5'd4);
        // R3: device address ignored, extreme addresses
        rd_frame(5'h1F, 5'd31);
        rd_frame(5'h0A, 5'd17, 0);
        wr_frame(5'h07, 5'd0, 16'h8001, 2'b01);
        rd_frame(5'h13, 5'd0);
        wr_frame(5'h1F, 5'd31, 16'hFFFF, 2'b11);
        rd_frame(5'h00, 5'd31);

        // R7: invalid opcodes
        hdr(2'b00, 5'h00, 5'd4, 2);
        for (int i = 0; i < 4; i++) begin
            repeat (HP) @(negedge clk);
            chk("R7 op00 no drive", mdio_oe, 1'b0);
            step(1'b1);
        end
        hdr(2'b11, 5'h03, 5'd9, 2);
        for (int i = 0; i < 4; i++) begin
            repeat (HP) @(negedge clk);
            chk("R7 op11 no drive", mdio_oe, 1'b0);
            step(1'b1);
        end
        chk("R7 no access queued", exp_q.size(), 0);
        rd_frame(5'h03, 5'd9);

        // R10: reset inside a write header
        for (int i = 0; i < 3; i++) step(1'b1);
        step(1'b0); step(1'b1); step(1'b0); step(1'b1); step(1'b0);
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1);
        chk("R10 idle after mid-header reset", {mdio_oe, 32'(exp_q.size())}, 0);
        wr_frame(5'h02, 5'd12, 16'h5AA5, 2'b00);
        rd_frame(5'h02, 5'd12);

        // R10: reset during read turnaround
        exp_q.push_back('{0, 5'd12, 16'h0, "R4"});
        hdr(2'b10, 5'h00, 5'd12, 2);
        repeat (HP) @(negedge clk);
        chk("R10 driving before reset", mdio_oe, 1'b1);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R10 drive dropped by reset", {mdio_oe, mdio_o}, 2'b00);
        rd_frame(5'h00, 5'd12);

        // R11: stretched high phase with data line toggling under it
        wr_frame(5'h01, 5'd21, 16'hC3A6, 2'b10, 7);
        rd_frame(5'h01, 5'd21);
        wr_frame(5'h01, 5'd22, 16'h0F0F, 2'b10, 0);
        rd_frame(5'h01, 5'd22);

        repeat (10) @(negedge clk);
        chk("R9 one access per frame", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule